// File: doc/BRIEF.md
# Bit-Plane Vector-Matrix Multiplier

This block multiplies an unsigned input vector X of `ROWS` elements by a `ROWS`-by-`COLS` matrix M held in local registers. It returns the product vector Y one element at a time. For each column j, the unit walks the bits of the X elements from most to least significant. On every step it takes the current bit of each X element, gates the matching entry of column j with it, and adds all of the gated entries in one combinational pass. The running total is doubled before that pass sum is added. After `EW` steps the total is exact, and it is emitted with its column index.

Software or a neighbouring block first fills the matrix through a simple write port while the unit is idle. It then presents X and pulses `start`. The columns come out in ascending order on a valid-qualified stream. A `done` pulse marks the last one. The matrix persists between runs, so one load can serve many input vectors.

Top module: `bitplane_vmm`

## Requirements
- R1: After reset `busy`, `out_valid` and `done` are 0, and every matrix entry reads as 0 in later products until it is written.
- R2: Each emitted `out_data` equals the exact unsigned sum over rows i of X[i]·M[i][col], with no overflow, for 8-bit X and M entries. X element i occupies bits [i*EW +: EW] of `x_vec`.
- R3: One accepted start produces exactly `COLS` results. Their `out_col` values run 0, 1, …, COLS-1 in order, with `out_valid` high for one cycle per result.
- R4: The result of column j appears with `out_valid` exactly EW·(j+1) clock edges after the edge that accepted `start`, so a full run takes COLS·EW cycles.
- R5: The vector is consumed most significant bit first. Bits of X that have weight 2^b contribute 2^b times their gated sum, so X values with only the top bit or only the bottom bit set give the correct results.
- R6: A write on the matrix port while `busy` is high is ignored, both in the current run and in later runs.
- R7: A `start` pulse while `busy` is high is ignored, and so is a change of `x_vec` after the accepting edge. The run in progress still yields the results of the captured vector and exactly `COLS` outputs.
- R8: `done` is high in exactly the cycle of the last result (column COLS-1), and `busy` is low in the cycle after it.
- R9: Writes while idle to (`wr_row`, `wr_col`) replace that entry. Entries keep their values across runs without reloading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Matrix entry write strobe (ignored while busy) |
| wr_row | input | RW | Row index of entry written |
| wr_col | input | CW | Column index of entry written |
| wr_data | input | EW | Entry value |
| x_vec | input | ROWS*EW | Input vector, element i at bits [i*EW +: EW] |
| start | input | 1 | Begin a run (ignored while busy) |
| busy | output | 1 | A run is in progress |
| out_valid | output | 1 | Result present on out_data/out_col |
| out_col | output | CW | Column index of the present result |
| out_data | output | 2*EW+RW | Product element Y[out_col] |
| done | output | 1 | Last result of the run |

## Verification
The bench uses vectors whose elements are all at full scale against an all-full-scale matrix. A narrowed accumulator or plane adder would wrap here and return a small value instead of 520200. X values with only the top bit or only the bottom bit set catch a reversed bit order or a missing doubling, which would scale a result by up to 128. Random vectors and matrices are checked against sums computed in the bench. Each result must arrive in its exact cycle and column order, so an off-by-one step count shows up as a mistimed or missing column. One run is disturbed by a matrix write, a second start and a changed vector while busy, and the following run reuses the matrix without reloading it. A design that let any of these through would report the wrong value for the last column or produce extra results.

// File: rtl/bvmm_pkg.sv
package bvmm_pkg;
    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    function automatic int unsigned log2_min1(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/bvmm_mat_store.sv
module bvmm_mat_store
    import bvmm_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int EW   = 8,
    localparam int RW  = log2_min1(ROWS),
    localparam int CW  = log2_min1(COLS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 lock,
    input  logic [RW-1:0]        wr_row,
    input  logic [CW-1:0]        wr_col,
    input  logic [EW-1:0]        wr_data,
    input  logic [CW-1:0]        rd_col,
    output logic [ROWS*EW-1:0]   col_data
);
    logic [EW-1:0] ent_q [ROWS][COLS];
    logic [EW-1:0] ent_d [ROWS][COLS];
    logic          wr_ok;

    assign wr_ok = wr_en && !lock;

    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                ent_d[r][c] = ent_q[r][c];
                if (wr_ok && (int'(wr_row) == r) && (int'(wr_col) == c)) begin
                    ent_d[r][c] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    ent_q[r][c] <= '0;
                end
            end
        end else begin
            ent_q <= ent_d;
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_rd
        assign col_data[r*EW +: EW] = ent_q[r][rd_col];
    end
endmodule

// File: rtl/bvmm_plane_sum.sv
module bvmm_plane_sum
    import bvmm_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int EW   = 8,
    localparam int RW  = log2_min1(ROWS),
    localparam int SW  = EW + RW
) (
    input  logic [ROWS-1:0]      plane,
    input  logic [ROWS*EW-1:0]   col_data,
    output logic [SW-1:0]        sum
);
    logic [SW-1:0] term [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_gate
        assign term[r] = plane[r] ? SW'(col_data[r*EW +: EW]) : '0;
    end

    always_comb begin
        sum = '0;
        for (int r = 0; r < ROWS; r++) begin
            sum = sum + term[r];
        end
    end
endmodule

// File: rtl/bvmm_seq.sv
module bvmm_seq
    import bvmm_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int EW   = 8,
    localparam int RW  = log2_min1(ROWS),
    localparam int CW  = log2_min1(COLS),
    localparam int BW  = log2_min1(EW),
    localparam int SW  = EW + RW,
    localparam int AW  = 2*EW + RW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ROWS*EW-1:0]   x_vec,
    input  logic [SW-1:0]        psum,
    output logic [ROWS-1:0]      plane,
    output logic [CW-1:0]        cur_col,
    output logic                 busy,
    output logic                 out_valid,
    output logic [CW-1:0]        out_col,
    output logic [AW-1:0]        out_data,
    output logic                 done
);
    localparam logic [BW-1:0] TOP_BIT  = BW'(EW - 1);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

    typedef struct packed {
        phase_e              phase;
        logic [ROWS*EW-1:0]  xv;
        logic [CW-1:0]       col;
        logic [BW-1:0]       bitn;
        logic [AW-1:0]       acc;
        logic                ov;
        logic [CW-1:0]       ocol;
        logic [AW-1:0]       odata;
        logic                fin;
    } seq_t;

    seq_t s_q, s_d;
    logic [AW-1:0] acc_nx;

    for (genvar r = 0; r < ROWS; r++) begin : g_plane
        assign plane[r] = s_q.xv[r*EW + int'(s_q.bitn)];
    end

    assign acc_nx = {s_q.acc[AW-2:0], 1'b0} + AW'(psum);

    always_comb begin
        s_d       = s_q;
        s_d.ov    = 1'b0;
        s_d.fin   = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase = PH_RUN;
                    s_d.xv    = x_vec;
                    s_d.col   = '0;
                    s_d.bitn  = TOP_BIT;
                    s_d.acc   = '0;
                end
            end
            PH_RUN: begin
                if (s_q.bitn == '0) begin
                    s_d.ov    = 1'b1;
                    s_d.ocol  = s_q.col;
                    s_d.odata = acc_nx;
                    s_d.acc   = '0;
                    s_d.bitn  = TOP_BIT;
                    if (s_q.col == LAST_COL) begin
                        s_d.phase = PH_IDLE;
                        s_d.fin   = 1'b1;
                        s_d.col   = '0;
                    end else begin
                        s_d.col = s_q.col + 1'b1;
                    end
                end else begin
                    s_d.acc  = acc_nx;
                    s_d.bitn = s_q.bitn - 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_col   = s_q.col;
    assign busy      = (s_q.phase == PH_RUN);
    assign out_valid = s_q.ov;
    assign out_col   = s_q.ocol;
    assign out_data  = s_q.odata;
    assign done      = s_q.fin;
endmodule

// File: rtl/bitplane_vmm.sv
module bitplane_vmm
    import bvmm_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int EW   = 8,
    localparam int RW  = log2_min1(ROWS),
    localparam int CW  = log2_min1(COLS),
    localparam int SW  = EW + RW,
    localparam int AW  = 2*EW + RW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RW-1:0]        wr_row,
    input  logic [CW-1:0]        wr_col,
    input  logic [EW-1:0]        wr_data,
    input  logic [ROWS*EW-1:0]   x_vec,
    input  logic                 start,
    output logic                 busy,
    output logic                 out_valid,
    output logic [CW-1:0]        out_col,
    output logic [AW-1:0]        out_data,
    output logic                 done
);
    logic [ROWS*EW-1:0] col_data;
    logic [ROWS-1:0]    plane;
    logic [CW-1:0]      cur_col;
    logic [SW-1:0]      psum;

    bvmm_mat_store #(.ROWS(ROWS), .COLS(COLS), .EW(EW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .lock     (busy),
        .wr_row   (wr_row),
        .wr_col   (wr_col),
        .wr_data  (wr_data),
        .rd_col   (cur_col),
        .col_data (col_data)
    );

    bvmm_plane_sum #(.ROWS(ROWS), .EW(EW)) u_sum (
        .plane    (plane),
        .col_data (col_data),
        .sum      (psum)
    );

    bvmm_seq #(.ROWS(ROWS), .COLS(COLS), .EW(EW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .x_vec     (x_vec),
        .psum      (psum),
        .plane     (plane),
        .cur_col   (cur_col),
        .busy      (busy),
        .out_valid (out_valid),
        .out_col   (out_col),
        .out_data  (out_data),
        .done      (done)
    );
endmodule

// File: rtl/bvmm_chk.sv
module bvmm_chk
    import bvmm_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int EW   = 8,
    localparam int RW  = log2_min1(ROWS),
    localparam int CW  = log2_min1(COLS),
    localparam int AW  = 2*EW + RW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          out_valid,
    input logic [CW-1:0] out_col,
    input logic [AW-1:0] out_data,
    input logic          done
);
    localparam longint unsigned EMAX = (64'd1 << EW) - 64'd1;
    localparam longint unsigned YMAX = longint'(ROWS) * EMAX * EMAX;

    int      edge_cnt;
    int      last_col;
    logic    seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt <= 0;
            last_col <= 0;
            seen     <= 1'b0;
        end else begin
            if (start && !busy) begin
                edge_cnt <= 0;
                seen     <= 1'b0;
            end else if (busy) begin
                edge_cnt <= edge_cnt + 1;
            end
            if (out_valid) begin
                last_col <= int'(out_col);
                seen     <= 1'b1;
            end
        end
    end

    // R1 / R3: nothing emerges while idle except the final result
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> !out_valid);

    // R2: result never exceeds the largest possible product sum
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (longint'(out_data) <= YMAX));

    // R3: columns appear in ascending order
    p_col_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen) |-> (int'(out_col) == last_col + 1));

    // R4: each result lands EW edges after the previous one
    p_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (edge_cnt == (int'(out_col) + 1) * EW));

    // R8: done only with the last column, and busy clears afterwards
    p_done_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_valid && (int'(out_col) == COLS - 1)));

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind bitplane_vmm bvmm_chk #(.ROWS(ROWS), .COLS(COLS), .EW(EW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .out_valid (out_valid),
    .out_col   (out_col),
    .out_data  (out_data),
    .done      (done)
);

// File: tb/sim_bitplane_vmm.sv
`timescale 1ns/1ps
module sim_bitplane_vmm;
    localparam int ROWS = 8;
    localparam int COLS = 8;
    localparam int EW   = 8;
    localparam int RW   = 3;
    localparam int CW   = 3;
    localparam int AW   = 2*EW + RW;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                wr_en = 1'b0;
    logic [RW-1:0]       wr_row = '0;
    logic [CW-1:0]       wr_col = '0;
    logic [EW-1:0]       wr_data = '0;
    logic [ROWS*EW-1:0]  x_vec = '0;
    logic                start = 1'b0;
    logic                busy, out_valid, done;
    logic [CW-1:0]       out_col;
    logic [AW-1:0]       out_data;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int mref [ROWS][COLS];
    int xref [ROWS];

    always #5 clk = ~clk;

    bitplane_vmm #(.ROWS(ROWS), .COLS(COLS), .EW(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
        .wr_col(wr_col), .wr_data(wr_data), .x_vec(x_vec), .start(start),
        .busy(busy), .out_valid(out_valid), .out_col(out_col),
        .out_data(out_data), .done(done)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic put(input int r, input int c, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_row = RW'(r); wr_col = CW'(c); wr_data = EW'(v);
        mref[r][c] = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_x();
        for (int r = 0; r < ROWS; r++) x_vec[r*EW +: EW] = EW'(xref[r]);
    endtask

    function automatic longint expect_y(input int c);
        longint s = 0;
        for (int r = 0; r < ROWS; r++) s += longint'(xref[r]) * longint'(mref[r][c]);
        return s;
    endfunction

    // disturb: write, restart and vector change while busy (R6, R7)
    task automatic do_run(input bit disturb, input string tag);
        int got = 0;
        logic [ROWS*EW-1:0] xs;
        set_x();
        xs = x_vec;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R4 busy after start", busy, 1);
        for (int k = 0; k <= COLS*EW + 3; k++) begin
            if (out_valid) begin
                chk({"R3 column order ", tag}, out_col, got);
                chk({"R2 product ", tag}, out_data, expect_y(got));
                chk({"R4 result cycle ", tag}, k, EW*(got+1));
                chk({"R8 done on last ", tag}, done, (got == COLS-1) ? 1 : 0);
                got++;
            end else begin
                chk({"R8 done alone ", tag}, done, 0);
            end
            if (got == COLS && !out_valid && k == COLS*EW + 1)
                chk({"R8 idle after done ", tag}, busy, 0);
            if (disturb && k == 3) begin
                wr_en = 1'b1; wr_row = '0; wr_col = CW'(COLS-1);
                wr_data = EW'(~mref[0][COLS-1]);
                start = 1'b1; x_vec = ~xs;
            end
            if (disturb && k == 4) begin
                wr_en = 1'b0; start = 1'b0; x_vec = xs;
            end
            @(negedge clk);
        end
        chk({"R3 result count ", tag}, got, COLS);
        chk({"R7 no restart ", tag}, busy, 0);
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++) begin
            xref[r] = 0;
            for (int c = 0; c < COLS; c++) mref[r][c] = 0;
        end
        repeat (3) @(negedge clk);
        chk("R1 busy at reset", busy, 0);
        chk("R1 valid at reset", out_valid, 0);
        chk("R1 done at reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: unwritten matrix gives zero products
        for (int r = 0; r < ROWS; r++) xref[r] = 255;
        do_run(1'b0, "R1 zero matrix");

        // R2: full scale, widest possible sums
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) put(r, c, 255);
        do_run(1'b0, "R2 full scale");

        // R5: only top bit, then only bottom bit
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) put(r, c, (r*37 + c*11 + 5) % 256);
        for (int r = 0; r < ROWS; r++) xref[r] = 128;
        do_run(1'b0, "R5 msb only");
        for (int r = 0; r < ROWS; r++) xref[r] = 1;
        do_run(1'b0, "R5 lsb only");
        for (int r = 0; r < ROWS; r++) xref[r] = (r % 2) ? 128 : 1;
        do_run(1'b0, "R5 mixed ends");

        // R9: identity-like matrix with a ramp vector
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) put(r, c, (r == c) ? 1 : 0);
        for (int r = 0; r < ROWS; r++) xref[r] = r * 30 + 3;
        do_run(1'b0, "R9 identity");

        // R2: random matrices and vectors
        for (int t = 0; t < 12; t++) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++) put(r, c, int'($urandom_range(0, 255)));
            for (int r = 0; r < ROWS; r++) xref[r] = int'($urandom_range(0, 255));
            do_run(1'b0, "R2 random");
            for (int r = 0; r < ROWS; r++) xref[r] = int'($urandom_range(0, 255));
            do_run(1'b0, "R9 reuse matrix");
        end

        // R6 / R7: disturbances while busy, then rerun without reload
        do_run(1'b1, "R6 R7 disturbed");
        do_run(1'b0, "R6 write dropped");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule